// File: doc/BRIEF.md
# Processor Status Trace Encoder

This block sits beside a processor core and turns its per-cycle activity into a 4-bit status code for an external debug probe. It also produces a 4-bit data-trace stream that carries captured 32-bit values such as operands and branch targets. Each cycle the core reports a set of event flags: instruction start, return-from-exception start, taken branch, exception processing, stopped, halted, entry to user mode and return to emulator mode. The encoder picks a single status code from these flags by a fixed priority. Stopped, halted and exception processing are states, so their codes are shown on every cycle the flag is held. Entry to user mode adds a single-cycle marker. A return to emulator mode shows its code for a fixed number of cycles.

Capture requests carry a value and a 2-bit marker selector. Each accepted value goes into a small FIFO. A serializer sends it out one nibble per cycle, least significant nibble first. In the cycle of the first nibble the status output shows the matching marker code. A request flagged as one of the two reset-time vector references is dropped. When the FIFO is full, a stall output tells the core to hold its request.

Top module: `pst_trace_encoder`

## Requirements
- R1: During and right after reset, with no events and no requests, `pst` is 0x0, `ddata` is 0 and `stall` is 0.
- R2: If no higher-priority condition applies, `pst` is 0x7 when `ev_rte_start` is set, otherwise 0x1 when `ev_insn_start` is set, otherwise 0x0. It is combinational, so it shows in the same cycle as the event.
- R3: While `ev_exception` is held, `pst` is 0xC on every cycle unless a higher-priority code applies. Exception processing ranks above return-from-exception start and instruction start.
- R4: `ev_branch_taken` gives `pst` 0x5 in that cycle, over the exception, user-entry and emulator-return codes.
- R5: `ev_halted` gives 0xF and `ev_stopped` gives 0xE on every cycle they are held. Halted wins over stopped, and both win over every other code, including capture markers.
- R6: `ev_user_entry` gives a 0x3 marker in that cycle, over the emulator-return, exception and instruction codes, and below the taken-branch code.
- R7: A one-cycle `ev_emu_return` gives 0xD for EMU_CYCLES consecutive cycles, starting in the event cycle. This code ranks above exception processing and below the user-entry, branch and capture-marker codes.
- R8: A capture accepted in cycle t with an idle serializer starts its frame in cycle t+2. Over cycles t+2 to t+9, `ddata` carries value bits [3:0], [7:4], … [31:28] in that order. In cycle t+2, `pst` shows the marker 0x8 | `cap_mk` (0x9, 0xA or 0xB for `cap_mk` 1, 2, 3). `ddata` is 0 whenever no frame is being sent.
- R9: Queued captures leave in arrival order. Each frame starts in the cycle right after the previous frame's last nibble, with no gap.
- R10: `stall` is 1 whenever the FIFO holds FIFO_DEPTH values. A `cap_req` in a cycle with `stall` at 1 is not accepted and never appears on `ddata`.
- R11: A `cap_req` with `cap_reset_ref` set is dropped. No frame and no marker follow from it.
- R12: The capture marker wins over the taken-branch and exception codes in its first-nibble cycle. When halted or stopped masks the marker, the frame's nibbles still go out on `ddata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_insn_start | input | 1 | An ordinary instruction starts this cycle |
| ev_rte_start | input | 1 | A return-from-exception starts this cycle |
| ev_branch_taken | input | 1 | A branch is taken this cycle |
| ev_exception | input | 1 | Exception processing is in progress |
| ev_stopped | input | 1 | Core is stopped |
| ev_halted | input | 1 | Core is halted |
| ev_user_entry | input | 1 | Core switches into user mode |
| ev_emu_return | input | 1 | Return-from-exception lands in emulator mode |
| cap_req | input | 1 | Request to trace `cap_value` |
| cap_reset_ref | input | 1 | Request belongs to a reset vector reference (drop it) |
| cap_mk | input | 2 | Marker selector, marker code is 0x8 \| cap_mk |
| cap_value | input | DATA_W | Value to trace |
| pst | output | 4 | Processor status code |
| ddata | output | NIB_W | Data-trace nibble |
| stall | output | 1 | Capture FIFO full, hold the request |

## Verification
The bench builds the block with DATA_W 32, NIB_W 4, FIFO_DEPTH 2 and EMU_CYCLES 4. The emulator-return hold is therefore longer than the default, so a branch can be placed in the middle of the hold window and the hold can be seen to resume after it. With a depth of two, three requests sent back to back fill the FIFO while the first frame is still being sent. This makes the stall window, the refused request, and the gap-free handover between consecutive frames all reachable in a few dozen cycles.

// File: rtl/pst_trace_pkg.sv
package pst_trace_pkg;

   typedef enum logic [3:0] {
      ST_CONTINUE = 4'h0,
      ST_INSN     = 4'h1,
      ST_USER     = 4'h3,
      ST_BRANCH   = 4'h5,
      ST_RTE      = 4'h7,
      ST_EXCEPT   = 4'hC,
      ST_EMU      = 4'hD,
      ST_STOP     = 4'hE,
      ST_HALT     = 4'hF
   } st_code_e;

   localparam logic [1:0] MARK_PREFIX = 2'b10;

   typedef struct packed {
      logic halted;
      logic stopped;
      logic branch;
      logic user_entry;
      logic exception;
      logic rte_start;
      logic insn_start;
   } core_ev_t;

endpackage

// File: rtl/pst_emu_hold.sv
module pst_emu_hold #(
   parameter int HOLD_CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trigger,
   output logic active
);
   localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (trigger) begin
         remain <= CW'(HOLD_CYCLES - 1);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign active = trigger | (remain != '0);

   // R7: the hold continues past the trigger cycle
   a_r7_hold_continues: assert property (@(posedge clk) disable iff (!rst_n)
      trigger |=> active);

endmodule

// File: rtl/pst_cap_fifo.sv
module pst_cap_fifo #(
   parameter int W     = 34,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         valid,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else begin
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign valid = (count != '0);
   assign full  = (count == CW'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] rd_ptr, wr_ptr;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_ptr <= '0;
               wr_ptr <= '0;
            end else begin
               if (push) wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + 1'b1;
               if (pop)  rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[wr_ptr] <= din;
         end

         assign dout = mem[rd_ptr];
      end
   endgenerate

   // R10: nothing is written into a full FIFO
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R9: only a held entry is taken out
   a_r9_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> valid);

endmodule

// File: rtl/pst_serializer.sv
module pst_serializer #(
   parameter int DATA_W = 32,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   input  logic [1:0]        src_mk,
   output logic              pop,
   output logic [NIB_W-1:0]  nib,
   output logic              first,
   output logic [1:0]        mk
);
   localparam int NIBS = DATA_W / NIB_W;
   localparam int CW   = (NIBS > 1) ? $clog2(NIBS) : 1;
   localparam logic [CW-1:0] LAST = CW'(NIBS - 1);

   logic              busy;
   logic [CW-1:0]     cnt;
   logic [DATA_W-1:0] shreg;
   logic [1:0]        mk_q;

   assign pop = src_valid && (!busy || cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
         mk_q  <= '0;
      end else if (pop) begin
         busy  <= 1'b1;
         cnt   <= '0;
         shreg <= src_data;
         mk_q  <= src_mk;
      end else if (busy) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
         end else begin
            cnt   <= cnt + 1'b1;
            shreg <= shreg >> NIB_W;
         end
      end
   end

   assign nib   = busy ? shreg[NIB_W-1:0] : '0;
   assign first = busy && (cnt == '0);
   assign mk    = mk_q;

   // R9: a frame runs through all its nibbles without a break
   a_r9_frame_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != LAST) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));
   // R8: a load always opens a new frame in the next cycle
   a_r8_load_opens_frame: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> first);

endmodule

// File: rtl/pst_prio.sv
module pst_prio
   import pst_trace_pkg::*;
(
   input  core_ev_t   ev,
   input  logic       emu_active,
   input  logic       cap_first,
   input  logic [1:0] cap_mk,
   output logic [3:0] code
);
   always_comb begin
      if (ev.halted)           code = ST_HALT;
      else if (ev.stopped)     code = ST_STOP;
      else if (cap_first)      code = {MARK_PREFIX, cap_mk};
      else if (ev.branch)      code = ST_BRANCH;
      else if (ev.user_entry)  code = ST_USER;
      else if (emu_active)     code = ST_EMU;
      else if (ev.exception)   code = ST_EXCEPT;
      else if (ev.rte_start)   code = ST_RTE;
      else if (ev.insn_start)  code = ST_INSN;
      else                     code = ST_CONTINUE;
   end
endmodule

// File: rtl/pst_trace_encoder.sv
module pst_trace_encoder
   import pst_trace_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NIB_W      = 4,
   parameter int FIFO_DEPTH = 2,
   parameter int EMU_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_insn_start,
   input  logic              ev_rte_start,
   input  logic              ev_branch_taken,
   input  logic              ev_exception,
   input  logic              ev_stopped,
   input  logic              ev_halted,
   input  logic              ev_user_entry,
   input  logic              ev_emu_return,
   input  logic              cap_req,
   input  logic              cap_reset_ref,
   input  logic [1:0]        cap_mk,
   input  logic [DATA_W-1:0] cap_value,
   output logic [3:0]        pst,
   output logic [NIB_W-1:0]  ddata,
   output logic              stall
);
   localparam int ENTRY_W = DATA_W + 2;

   initial begin
      if (NIB_W < 1 || DATA_W % NIB_W != 0)
         $fatal(1, "DATA_W must be a whole number of nibbles");
      if (FIFO_DEPTH < 1)
         $fatal(1, "FIFO_DEPTH must be at least 1");
      if (EMU_CYCLES < 2)
         $fatal(1, "EMU_CYCLES must be at least 2");
   end

   core_ev_t            ev;
   logic                accept;
   logic                fifo_full, fifo_valid, fifo_pop;
   logic [ENTRY_W-1:0]  fifo_dout;
   logic                emu_active;
   logic                ser_first;
   logic [1:0]          ser_mk;

   assign ev.halted     = ev_halted;
   assign ev.stopped    = ev_stopped;
   assign ev.branch     = ev_branch_taken;
   assign ev.user_entry = ev_user_entry;
   assign ev.exception  = ev_exception;
   assign ev.rte_start  = ev_rte_start;
   assign ev.insn_start = ev_insn_start;

   assign accept = cap_req && !cap_reset_ref && !fifo_full;
   assign stall  = fifo_full;

   pst_cap_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   ({cap_mk, cap_value}),
      .pop   (fifo_pop),
      .dout  (fifo_dout),
      .valid (fifo_valid),
      .full  (fifo_full)
   );

   pst_serializer #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (fifo_valid),
      .src_data  (fifo_dout[DATA_W-1:0]),
      .src_mk    (fifo_dout[ENTRY_W-1:DATA_W]),
      .pop       (fifo_pop),
      .nib       (ddata),
      .first     (ser_first),
      .mk        (ser_mk)
   );

   pst_emu_hold #(.HOLD_CYCLES(EMU_CYCLES)) u_emu (
      .clk     (clk),
      .rst_n   (rst_n),
      .trigger (ev_emu_return),
      .active  (emu_active)
   );

   pst_prio u_prio (
      .ev         (ev),
      .emu_active (emu_active),
      .cap_first  (ser_first),
      .cap_mk     (ser_mk),
      .code       (pst)
   );

   // R5: halted dominates every other source
   a_r5_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_halted |-> pst == 4'hF);
   // R5: stopped dominates all but halted
   a_r5_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stopped && !ev_halted) |-> pst == 4'hE);
   // R3: exception code held when nothing ranks above it
   a_r3_exception_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_exception && !ev_halted && !ev_stopped && !ser_first && !ev_branch_taken
       && !ev_user_entry && !emu_active) |-> pst == 4'hC);
   // R11: reset vector references never enter the queue
   a_r11_reset_ref_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_req && cap_reset_ref) |-> !accept);
   // R10: a stalled request is refused
   a_r10_stall_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !accept);

endmodule

// File: tb/tb_pst_trace_encoder.sv
`timescale 1ns/1ps
module tb_pst_trace_encoder;
   localparam int DATA_W = 32;
   localparam int NIB_W  = 4;
   localparam int DEPTH  = 2;
   localparam int EMU    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_insn_start = 0, ev_rte_start = 0, ev_branch_taken = 0, ev_exception = 0;
   logic ev_stopped = 0, ev_halted = 0, ev_user_entry = 0, ev_emu_return = 0;
   logic cap_req = 0, cap_reset_ref = 0;
   logic [1:0] cap_mk = 0;
   logic [DATA_W-1:0] cap_value = 0;
   logic [3:0] pst;
   logic [NIB_W-1:0] ddata;
   logic stall;

   always #5 clk = ~clk;

   pst_trace_encoder #(.DATA_W(DATA_W), .NIB_W(NIB_W), .FIFO_DEPTH(DEPTH),
                       .EMU_CYCLES(EMU)) dut (
      .clk(clk), .rst_n(rst_n),
      .ev_insn_start(ev_insn_start), .ev_rte_start(ev_rte_start),
      .ev_branch_taken(ev_branch_taken), .ev_exception(ev_exception),
      .ev_stopped(ev_stopped), .ev_halted(ev_halted),
      .ev_user_entry(ev_user_entry), .ev_emu_return(ev_emu_return),
      .cap_req(cap_req), .cap_reset_ref(cap_reset_ref), .cap_mk(cap_mk),
      .cap_value(cap_value), .pst(pst), .ddata(ddata), .stall(stall)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   int next_free = 0;
   bit mon_en = 0;
   bit done = 0;

   typedef struct {
      int          start;
      logic [3:0]  mk;
      logic [31:0] val;
   } exp_t;
   exp_t exp_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_ev();
      ev_insn_start = 0; ev_rte_start = 0; ev_branch_taken = 0; ev_exception = 0;
      ev_stopped = 0; ev_halted = 0; ev_user_entry = 0; ev_emu_return = 0;
   endtask

   task automatic pst_at(input string tag, input logic [3:0] exp);
      @(negedge clk);
      chk(tag, pst, exp);
      tick();
   endtask

   // driver: pushes the expected frame, then presents the request
   task automatic send_cap(input logic [1:0] mk, input logic [31:0] v);
      exp_t it;
      while (stall) tick();
      cap_req = 1; cap_reset_ref = 0; cap_mk = mk; cap_value = v;
      it.start = (cyc + 2 > next_free) ? cyc + 2 : next_free;
      it.mk = {2'b10, mk};
      it.val = v;
      next_free = it.start + DATA_W / NIB_W;
      exp_q.push_back(it);
      tick();
      cap_req = 0;
   endtask

   // monitor: pops and compares frames as they appear
   int left = 0;
   logic [31:0] cur;
   always @(negedge clk) begin
      if (mon_en) begin
         if (left == 0) begin
            if (pst[3:2] == 2'b10) begin
               if (exp_q.size() == 0) begin
                  chk("R9/R10/R11 unexpected frame", {28'd0, pst}, 32'd0);
               end else begin
                  exp_t it;
                  it = exp_q.pop_front();
                  chk("R8 marker code", {28'd0, pst}, {28'd0, it.mk});
                  chk("R8/R9 frame start cycle", cyc, it.start);
                  chk("R8 first nibble", {28'd0, ddata}, {28'd0, it.val[3:0]});
                  cur = it.val >> 4;
                  left = DATA_W / NIB_W - 1;
               end
            end else begin
               chk("R8 ddata idle zero", {28'd0, ddata}, 32'd0);
            end
         end else begin
            chk("R9 nibble order", {28'd0, ddata}, {28'd0, cur[3:0]});
            cur = cur >> 4;
            left--;
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         chk("R1 pst in reset", {28'd0, pst}, 32'h0);
         chk("R1 stall in reset", {31'd0, stall}, 32'h0);
      end
      tick();
      rst_n = 1;
      @(negedge clk);
      chk("R1 pst after reset", {28'd0, pst}, 32'h0);
      chk("R1 ddata after reset", {28'd0, ddata}, 32'h0);
      chk("R1 stall after reset", {31'd0, stall}, 32'h0);
      tick();
      mon_en = 1;

      // R2: base codes
      ev_insn_start = 1;                   pst_at("R2 insn start", 4'h1);
      ev_rte_start = 1;                    pst_at("R2 rte over insn", 4'h7);
      clear_ev();                          pst_at("R2 continue", 4'h0);

      // R3: exception held over several cycles
      ev_exception = 1; ev_insn_start = 1; pst_at("R3 exception c0", 4'hC);
      ev_rte_start = 1;                    pst_at("R3 exception c1", 4'hC);
      ev_insn_start = 0; ev_rte_start = 0; pst_at("R3 exception c2", 4'hC);

      // R4: branch overrides exception
      ev_branch_taken = 1;                 pst_at("R4 branch over exception", 4'h5);
      ev_user_entry = 1;                   pst_at("R4 branch over user", 4'h5);

      // R6: user-entry marker
      ev_branch_taken = 0; ev_insn_start = 1;
                                           pst_at("R6 user over exception", 4'h3);
      clear_ev();

      // R7: emulator return hold with exception held
      ev_exception = 1; ev_emu_return = 1; pst_at("R7 emu c0", 4'hD);
      ev_emu_return = 0;                   pst_at("R7 emu c1", 4'hD);
      ev_branch_taken = 1;                 pst_at("R7 branch within hold", 4'h5);
      ev_branch_taken = 0;                 pst_at("R7 emu c3", 4'hD);
                                           pst_at("R7 hold ended", 4'hC);
      clear_ev();                          pst_at("R7 idle", 4'h0);

      // R5: stopped and halted
      ev_stopped = 1; ev_branch_taken = 1; ev_exception = 1; ev_user_entry = 1;
                                           pst_at("R5 stopped c0", 4'hE);
      ev_branch_taken = 0;                 pst_at("R5 stopped c1", 4'hE);
      ev_halted = 1;                       pst_at("R5 halted over stopped", 4'hF);
      ev_stopped = 0;                      pst_at("R5 halted held", 4'hF);
      clear_ev();                          pst_at("R5 released", 4'h0);

      // R8: single frame
      send_cap(2'd1, 32'h1234_5678);
      repeat (12) tick();

      // R9 / R10: three back to back, stall and refused request
      send_cap(2'd3, 32'hCAFE_0142);
      send_cap(2'd2, 32'h8765_4321);
      send_cap(2'd1, 32'h0F1E_2D3C);
      @(negedge clk);
      chk("R10 stall with full fifo", {31'd0, stall}, 32'h1);
      tick();
      cap_req = 1; cap_mk = 2'd3; cap_value = 32'hDEAD_BEEF;
      tick();
      cap_req = 0;
      repeat (4) tick();
      @(negedge clk);
      chk("R10 stall still high", {31'd0, stall}, 32'h1);
      tick();
      @(negedge clk);
      chk("R10 stall released", {31'd0, stall}, 32'h0);
      tick();
      while (exp_q.size() != 0) tick();
      repeat (10) tick();

      // R11: reset vector reference dropped
      cap_req = 1; cap_reset_ref = 1; cap_mk = 2'd2; cap_value = 32'h0000_0004;
      tick();
      cap_req = 0; cap_reset_ref = 0;
      repeat (12) tick();
      chk("R11 queue still empty", exp_q.size(), 0);

      // R12: marker against branch, halted and stopped (monitor off)
      mon_en = 0;
      cap_req = 1; cap_mk = 2'd2; cap_value = 32'hA5C3_0F96;
      tick();
      cap_req = 0;
      tick();
      ev_branch_taken = 1; ev_exception = 1;
      @(negedge clk);
      chk("R12 marker over branch", {28'd0, pst}, 32'hA);
      chk("R12 nibble0", {28'd0, ddata}, 32'h6);
      tick();
      ev_branch_taken = 0; ev_halted = 1;
      @(negedge clk);
      chk("R12 halted while streaming", {28'd0, pst}, 32'hF);
      chk("R12 nibble1 under halt", {28'd0, ddata}, 32'h9);
      tick();
      clear_ev();
      repeat (10) tick();
      cap_req = 1; cap_mk = 2'd3; cap_value = 32'h0000_00B7;
      tick();
      cap_req = 0;
      tick();
      ev_stopped = 1;
      @(negedge clk);
      chk("R12 stopped masks marker", {28'd0, pst}, 32'hE);
      chk("R12 nibble0 under stop", {28'd0, ddata}, 32'h7);
      tick();
      clear_ev();
      @(negedge clk);
      chk("R12 nibble1 after stop", {28'd0, ddata}, 32'hB);
      repeat (10) tick();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule